// File: doc/BRIEF.md
# Address-Programmed Minterm Lookup Array

This block is a small programmable logic array over N_IN inputs, with N_IN from 1 to 4. It keeps one sticky configuration bit for each of the 2^N_IN minterms. Software never writes the bits as a word. Instead, a programming stream visits addresses one per cycle. Each valid visit sets the bit of the minterm tied to that address. The order of visits is the path. The set of visited addresses decides the function.

The output is the OR, over all minterms, of the minterm's configuration bit AND-ed with the match of that minterm against the current input vector. Internally the array is built recursively. An N-input array is two (N-1)-input halves, and the top input picks between them. The recursion ends at 1-input arrays of two bits each.

Programming and evaluation may overlap. A synchronous clear wipes the configuration. To get a multi-output function, place several arrays side by side on the same inputs.

Top module: `mlut_array`

## Requirements
- R1: While rst_ni is low, every configuration bit is 0, err_o is 0 and f_o is 0.
- R2: An array with no bit set drives f_o = 0 for every input vector.
- R3: Address k, for 1 <= k <= 2^N_IN, belongs to minterm k-1. The minterm index of an input vector is x_i read as an unsigned binary number with x_i[N_IN-1] as the most significant bit. So a1 is the all-zero input and a(2^N_IN) is the all-one input.
- R4: A strobe prog_i with a valid address sets that minterm's bit at the clock edge. From that edge onward, f_o is 1 whenever x_i selects that minterm.
- R5: A set bit stays set through any later strobes, repeated visits and input changes. Only a clear or a reset removes it.
- R6: A strobe with address 0 or an address above 2^N_IN changes no configuration bit. It sets err_o, and err_o then stays 1 until a clear or a reset.
- R7: clr_i is synchronous. At the next edge it returns every configuration bit and err_o to 0. It wins over a strobe given in the same cycle.
- R8: With N_IN = 4, visiting a1, a2, a4 gives f_o = 1 exactly for minterms 0, 1 and 3. Visiting a1, a3, a4 gives f_o = 1 exactly for minterms 0, 2 and 3.
- R9: f_o follows x_i combinationally within the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all bits and of the error flag |
| prog_i | input | 1 | Programming strobe, one visit per cycle |
| addr_i | input | ADDR_W | Visited address, 1-based |
| x_i | input | N_IN | Input vector under evaluation |
| f_o | output | 1 | Function output |
| err_o | output | 1 | Sticky out-of-range visit flag |

## Verification
After each programming path, the bench sweeps x_i over all sixteen minterms. This sweep exposes both bits that are set by mistake and bits that are missing.

The two reference paths, a1-a2-a4 and a1-a3-a4, differ only in whether X0 or X1 carries the weight of 2. Together they catch swapped halves or a reversed bit order in the recursive tree.

The boundary addresses a1 and a16 test the ends of the 1-based mapping. Addresses 0, 17 and 31 test rejection and the sticky flag. A strobe issued together with a clear tests the priority between them. Strobes issued while x_i changes every cycle test that programming and evaluation can overlap.

// File: rtl/mlut_pkg.sv
package mlut_pkg;
  function automatic int unsigned n_terms(input int unsigned n);
    return 32'd1 << n;
  endfunction
endpackage

// File: rtl/mlut_cfg_bit.sv
module mlut_cfg_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (clr_i)  q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
  end
endmodule

// File: rtl/mlut_addr_dec.sv
module mlut_addr_dec #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned N_TERMS = mlut_pkg::n_terms(N_IN)
) (
  input  logic                 prog_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [N_TERMS-1:0]   set_o,
  output logic                 bad_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(N_TERMS);

  logic in_range;
  assign in_range = (addr_i != '0) && ({1'b0, addr_i} <= LIMIT);
  assign bad_o    = prog_i && !in_range;

  // address k selects minterm k-1
  for (genvar i = 0; i < N_TERMS; i++) begin : g_dec
    assign set_o[i] = prog_i && (addr_i == ADDR_W'(i + 1));
  end
endmodule

// File: rtl/mlut_tree.sv
module mlut_tree #(
  parameter int unsigned N = 4,
  localparam int unsigned W = mlut_pkg::n_terms(N)
) (
  input  logic [W-1:0] cfg_i,
  input  logic [N-1:0] x_i,
  output logic         f_o
);
  if (N == 1) begin : g_leaf
    assign f_o = x_i[0] ? cfg_i[1] : cfg_i[0];
  end else begin : g_node
    localparam int unsigned HW = W / 2;
    logic f_hi, f_lo;
    mlut_tree #(.N(N-1)) u_hi (.cfg_i(cfg_i[W-1:HW]), .x_i(x_i[N-2:0]), .f_o(f_hi));
    mlut_tree #(.N(N-1)) u_lo (.cfg_i(cfg_i[HW-1:0]), .x_i(x_i[N-2:0]), .f_o(f_lo));
    // f = f_hi & x[top] | f_lo & ~x[top]
    assign f_o = x_i[N-1] ? f_hi : f_lo;
  end
endmodule

// File: rtl/mlut_array.sv
module mlut_array #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              prog_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_IN-1:0]   x_i,
  output logic              f_o,
  output logic              err_o
);
  localparam int unsigned N_TERMS = mlut_pkg::n_terms(N_IN);

  logic [N_TERMS-1:0] set_v;
  logic [N_TERMS-1:0] cfg_q;
  logic               bad;

  mlut_addr_dec #(.N_IN(N_IN), .ADDR_W(ADDR_W)) u_dec (
    .prog_i(prog_i), .addr_i(addr_i), .set_o(set_v), .bad_o(bad)
  );

  for (genvar i = 0; i < N_TERMS; i++) begin : g_cell
    mlut_cfg_bit u_bit (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
      .set_i(set_v[i]), .q_o(cfg_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_o <= 1'b0;
    else if (clr_i)  err_o <= 1'b0;
    else if (bad)    err_o <= 1'b1;
  end

  mlut_tree #(.N(N_IN)) u_tree (.cfg_i(cfg_q), .x_i(x_i), .f_o(f_o));
endmodule

// File: rtl/mlut_array_chk.sv
module mlut_array_chk #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned N_TERMS = mlut_pkg::n_terms(N_IN)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_i,
  input logic               prog_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               f_o,
  input logic               err_o,
  input logic [N_TERMS-1:0] cfg_q
);
  logic [N_TERMS-1:0] want;
  logic               oob;

  always_comb begin
    want = '0;
    oob  = prog_i;
    for (int k = 1; k <= N_TERMS; k++) begin
      if (prog_i && int'(addr_i) == k) begin
        want[k-1] = 1'b1;
        oob       = 1'b0;
      end
    end
  end

  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (cfg_q == '0 && !err_o && !f_o));

  a_r2_cleared_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> !f_o);

  a_r4_visit_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && !clr_i) |=> ((cfg_q & $past(want)) == $past(want)));

  a_r5_sticky_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((cfg_q & $past(cfg_q)) == $past(cfg_q)));

  a_r6_bad_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oob && !clr_i) |=> (err_o && $stable(cfg_q)));

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cfg_q == '0 && !err_o));
endmodule

bind mlut_array mlut_array_chk #(.N_IN(N_IN), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .prog_i(prog_i),
  .addr_i(addr_i), .f_o(f_o), .err_o(err_o), .cfg_q(cfg_q)
);

// File: tb/mlut_array_tb.sv
`timescale 1ns/1ps
module mlut_array_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, prog = 1'b0;
  logic [4:0] addr = '0;
  logic [3:0] x = '0;
  logic       f, err;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  bit [15:0] ref_cfg;
  bit        ref_err;

  always #10 clk = ~clk;

  mlut_array #(.N_IN(4), .ADDR_W(5)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .prog_i(prog),
    .addr_i(addr), .x_i(x), .f_o(f), .err_o(err)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cfg = '0; ref_err = 1'b0;
    end else if (clr) begin
      ref_cfg = '0; ref_err = 1'b0;
    end else if (prog) begin
      if (addr >= 1 && addr <= 16) ref_cfg[addr - 1] = 1'b1;
      else ref_err = 1'b1;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b (x=%0d t=%0t)", tag, act, exp, x, $time);
    end
  endtask

  task automatic step(input logic c, input logic p, input int a, input int xi, input string tag);
    @(negedge clk);
    clr = c; prog = p; addr = 5'(a); x = 4'(xi);
    #1;
    chk(f, ref_cfg[x], {tag, " f_o"});
    chk(err, ref_err, {tag, " err_o"});
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 16; i++) step(1'b0, 1'b0, 0, i, tag);
  endtask

  task automatic sweep_exp(input bit [15:0] exp, input string tag);
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 1'b0, 0, i, tag);
      chk(f, exp[i], {tag, " explicit"});
    end
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 0, i, "R1");
      chk(f, 1'b0, "R1 f_o in reset");
    end
    @(negedge clk); rst_n = 1'b1;
    sweep_exp(16'h0000, "R2");
    // R8 first path, R4 visibility
    step(1'b0, 1'b1, 1, 0, "R4");
    step(1'b0, 1'b1, 2, 0, "R4");
    step(1'b0, 1'b1, 4, 1, "R4");
    sweep_exp(16'h000B, "R8 path a1 a2 a4");
    // R7: clear with strobe same cycle
    step(1'b1, 1'b1, 5, 3, "R7");
    sweep_exp(16'h0000, "R7 clear wins");
    // R8 second path
    step(1'b0, 1'b1, 1, 5, "R8");
    step(1'b0, 1'b1, 3, 6, "R8");
    step(1'b0, 1'b1, 4, 7, "R8");
    sweep_exp(16'h000D, "R8 path a1 a3 a4");
    step(1'b1, 1'b0, 0, 0, "R7");
    // R3 boundaries, overlap with changing x
    step(1'b0, 1'b1, 16, 15, "R3");
    step(1'b0, 1'b0, 0, 15, "R3 a16 visible");
    chk(f, 1'b1, "R3 a16 maps to all-ones");
    step(1'b0, 1'b1, 1, 0, "R3");
    step(1'b0, 1'b0, 0, 0, "R3 a1 visible");
    chk(f, 1'b1, "R3 a1 maps to all-zeros");
    sweep_exp(16'h8001, "R3 ends");
    // R5 sticky through revisits
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1, i, "R5");
    step(1'b0, 1'b1, 7, 9, "R5");
    sweep_exp(16'h8041, "R5 sticky");
    // R6 out of range
    step(1'b0, 1'b1, 0, 2, "R6");
    step(1'b0, 1'b0, 0, 2, "R6");
    chk(err, 1'b1, "R6 err after addr 0");
    step(1'b0, 1'b1, 17, 4, "R6");
    step(1'b0, 1'b1, 31, 8, "R6");
    sweep_exp(16'h8041, "R6 no bit changed");
    chk(err, 1'b1, "R6 err sticky");
    // R7 clears error
    step(1'b1, 1'b0, 0, 0, "R7");
    step(1'b0, 1'b0, 0, 0, "R7");
    chk(err, 1'b0, "R7 err cleared");
    // fill all in reverse, R9 combinational sweep
    for (int a = 16; a >= 1; a--) step(1'b0, 1'b1, a, a % 16, "R4");
    sweep_exp(16'hFFFF, "R9");
    step(1'b1, 1'b0, 0, 0, "R7");
    sweep_exp(16'h0000, "R2 after clear");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule